// File: doc/BRIEF.md
# Boot-Mapped Translation Buffer

This block translates 4KB effective pages into real pages. It holds a small set of entries that software writes by index. It also holds one extra entry that is loaded at reset. That extra entry lets boot code fetch and load from the highest page of the address space before software has set up any mapping.

A lookup is combinational. The caller presents a page number, a process ID, two address-space bits and an access kind. In the same cycle the block answers with hit, miss, the real page number and a permission fault.

The boot entry never allows stores. It is discarded permanently, until the next reset, in two cases:
- a context-synchronize pulse arrives, or
- a store hits the boot entry and faults.

After either event only the software-written entries translate.

Top module: `boot_tlb`

## Requirements
- R1: After reset all 8 indexed entries are invalid. The boot entry is valid and maps page 0xFFFFF to real page 0xFFFFF with TID 0 and TS 0. It allows fetch and read but not write.
- R2: A valid store (access code 2) that resolves to the boot entry returns hit=1 and fault=1. From the next cycle on, the boot entry no longer matches.
- R3: A pulse on `sync_i` invalidates the boot entry from the next cycle on. Only a reset makes it valid again.
- R4: An entry with TID 0 matches any process ID. An entry with a nonzero TID matches only when its TID equals `lk_pid_i`.
- R5: An entry's TS bit must equal the request's space bit. Fetches (code 0) use `lk_is_i`; reads and writes use `lk_ds_i`.
- R6: Access codes are 0 = fetch, 1 = read, 2 = write, and 3 = treated as read. A hit sets fault=1 exactly when the selected entry lacks the permission that the access needs (fetch, read or write).
- R7: When several indexed entries match, the lowest index supplies the real page number and the permissions. Any matching indexed entry takes precedence over the boot entry.
- R8: A valid request that matches nothing returns miss=1, hit=0, fault=0 and real page 0.
- R9: An entry write takes effect on the clock edge. A lookup in the same cycle still sees the old contents; the next cycle sees the new ones.
- R10: With `lk_valid_i` low, hit, miss and fault are 0 and the real page is 0. An idle store pattern does not discard the boot entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid_i | input | 1 | Lookup request present |
| lk_epn_i | input | 20 | Effective page number |
| lk_pid_i | input | 8 | Current process ID |
| lk_is_i | input | 1 | Instruction address-space bit |
| lk_ds_i | input | 1 | Data address-space bit |
| lk_acc_i | input | 2 | Access kind (0 fetch, 1 read, 2 write, 3 read) |
| hit_o | output | 1 | Translation found |
| miss_o | output | 1 | Valid request with no matching entry |
| fault_o | output | 1 | Hit lacking the needed permission |
| rpn_o | output | 20 | Real page number (0 unless hit) |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 3 | Entry index to write |
| wr_valid_i | input | 1 | Valid bit for written entry |
| wr_epn_i | input | 20 | Effective page number for written entry |
| wr_rpn_i | input | 20 | Real page number for written entry |
| wr_tid_i | input | 8 | TID for written entry |
| wr_ts_i | input | 1 | Address-space bit for written entry |
| wr_px_i | input | 1 | Fetch permission |
| wr_pr_i | input | 1 | Read permission |
| wr_pw_i | input | 1 | Write permission |
| sync_i | input | 1 | Context-synchronize pulse |

## Verification
Directed lookups cover the following cases:
- The boot page is probed for fetch, read and store. This separates the boot entry's fixed permissions from its discard path.
- Pairs of requests differ only in process ID or in a space bit. These isolate the TID wildcard from the TS compare, and the fetch space bit from the data space bit.
- Overlapping entries at the same page show whether lowest-index priority holds, and whether indexed entries take precedence over the boot entry.
- Back-to-back write-then-lookup cycles expose an early or a late write.

A long random mix of writes, lookups and sync pulses over a few pages is then compared each cycle against a behavioural model.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    localparam int EPN_W = 20;
    localparam int RPN_W = 20;
    localparam int TID_W = 8;

    localparam logic [EPN_W-1:0] BOOT_EPN = '1;
    localparam logic [RPN_W-1:0] BOOT_RPN = '1;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic             valid;
        logic [EPN_W-1:0] epn;
        logic [RPN_W-1:0] rpn;
        logic [TID_W-1:0] tid;
        logic             ts;
        logic             px;
        logic             pr;
        logic             pw;
    } tlb_ent_t;

    typedef struct packed {
        logic [EPN_W-1:0] epn;
        logic [TID_W-1:0] pid;
        logic             space;
        acc_e             acc;
    } tlb_req_t;

    function automatic logic space_of(input acc_e acc, input logic is_bit, input logic ds_bit);
        return (acc == ACC_FETCH) ? is_bit : ds_bit;
    endfunction

    function automatic logic ent_match(input tlb_ent_t e, input tlb_req_t r);
        return e.valid && (e.epn == r.epn) && (e.ts == r.space)
            && ((e.tid == '0) || (e.tid == r.pid));
    endfunction

    function automatic logic perm_ok(input tlb_ent_t e, input acc_e acc);
        case (acc)
            ACC_FETCH: return e.px;
            ACC_WRITE: return e.pw;
            default:   return e.pr;
        endcase
    endfunction
endpackage

// File: rtl/tlb_entry_array.sv
`timescale 1ns/1ps
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int NUM_ENT = 8,
    localparam int IDX_W = $clog2(NUM_ENT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  tlb_ent_t                 wr_ent,
    output tlb_ent_t [NUM_ENT-1:0]   ents
);
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ents[g] <= wr_ent;
            end
        end

        // R1
        reset_invalid_chk: assert property (@(posedge clk)
            rst |=> !ents[g].valid);

        // R9
        untouched_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && (wr_idx == IDX_W'(g))) |=> $stable(ents[g]));
    end
endmodule

// File: rtl/tlb_prio_sel.sv
`timescale 1ns/1ps
module tlb_prio_sel
    import tlb_pkg::*;
#(
    parameter int NUM_ENT = 8
) (
    input  tlb_ent_t [NUM_ENT-1:0] ents,
    input  tlb_req_t               req,
    output logic                   any_hit,
    output tlb_ent_t               sel_ent
);
    logic [NUM_ENT-1:0] match_vec;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        assign match_vec[g] = ent_match(ents[g], req);
    end

    always_comb begin
        any_hit = 1'b0;
        sel_ent = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any_hit = 1'b1;
                sel_ent = ents[i];
            end
        end
    end
endmodule

// File: rtl/tlb_boot_slot.sv
`timescale 1ns/1ps
module tlb_boot_slot
    import tlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_kill,
    input  logic     store_kill,
    output tlb_ent_t boot_ent
);
    logic alive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alive_q <= 1'b1;
        end else if (sync_kill || store_kill) begin
            alive_q <= 1'b0;
        end
    end

    always_comb begin
        boot_ent       = '0;
        boot_ent.valid = alive_q;
        boot_ent.epn   = BOOT_EPN;
        boot_ent.rpn   = BOOT_RPN;
        boot_ent.tid   = '0;
        boot_ent.ts    = 1'b0;
        boot_ent.px    = 1'b1;
        boot_ent.pr    = 1'b1;
        boot_ent.pw    = 1'b0;
    end

    // R3
    sync_drop_chk: assert property (@(posedge clk) disable iff (rst)
        sync_kill |=> !alive_q);

    // R3
    no_revive_chk: assert property (@(posedge clk) disable iff (rst)
        !alive_q |=> !alive_q);

    // R2
    store_drop_chk: assert property (@(posedge clk) disable iff (rst)
        store_kill |=> !alive_q);
endmodule

// File: rtl/boot_tlb.sv
`timescale 1ns/1ps
module boot_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENT = 8,
    localparam int IDX_W = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid_i,
    input  logic [19:0]      lk_epn_i,
    input  logic [7:0]       lk_pid_i,
    input  logic             lk_is_i,
    input  logic             lk_ds_i,
    input  logic [1:0]       lk_acc_i,
    output logic             hit_o,
    output logic             miss_o,
    output logic             fault_o,
    output logic [19:0]      rpn_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_valid_i,
    input  logic [19:0]      wr_epn_i,
    input  logic [19:0]      wr_rpn_i,
    input  logic [7:0]       wr_tid_i,
    input  logic             wr_ts_i,
    input  logic             wr_px_i,
    input  logic             wr_pr_i,
    input  logic             wr_pw_i,
    input  logic             sync_i
);
    tlb_req_t               req;
    tlb_ent_t               wr_ent;
    tlb_ent_t [NUM_ENT-1:0] ents;
    tlb_ent_t               arch_ent;
    tlb_ent_t               boot_ent;
    tlb_ent_t               chosen;
    logic                   arch_hit;
    logic                   boot_hit;
    logic                   any_hit;
    logic                   perm_bad;
    logic                   boot_store_kill;

    always_comb begin
        req.epn   = lk_epn_i;
        req.pid   = lk_pid_i;
        req.acc   = acc_e'(lk_acc_i);
        req.space = space_of(acc_e'(lk_acc_i), lk_is_i, lk_ds_i);
    end

    always_comb begin
        wr_ent.valid = wr_valid_i;
        wr_ent.epn   = wr_epn_i;
        wr_ent.rpn   = wr_rpn_i;
        wr_ent.tid   = wr_tid_i;
        wr_ent.ts    = wr_ts_i;
        wr_ent.px    = wr_px_i;
        wr_ent.pr    = wr_pr_i;
        wr_ent.pw    = wr_pw_i;
    end

    tlb_entry_array #(.NUM_ENT(NUM_ENT)) u_array (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en_i),
        .wr_idx (wr_idx_i),
        .wr_ent (wr_ent),
        .ents   (ents)
    );

    tlb_prio_sel #(.NUM_ENT(NUM_ENT)) u_sel (
        .ents    (ents),
        .req     (req),
        .any_hit (arch_hit),
        .sel_ent (arch_ent)
    );

    tlb_boot_slot u_boot (
        .clk        (clk),
        .rst        (rst),
        .sync_kill  (sync_i),
        .store_kill (boot_store_kill),
        .boot_ent   (boot_ent)
    );

    always_comb begin
        boot_hit = ent_match(boot_ent, req) && !arch_hit;
        any_hit  = lk_valid_i && (arch_hit || boot_hit);
        chosen   = arch_hit ? arch_ent : boot_ent;
        perm_bad = any_hit && !perm_ok(chosen, req.acc);
        boot_store_kill = lk_valid_i && boot_hit && perm_bad
                          && (req.acc == ACC_WRITE);
    end

    assign hit_o   = any_hit;
    assign miss_o  = lk_valid_i && !any_hit;
    assign fault_o = perm_bad;
    assign rpn_o   = any_hit ? chosen.rpn : '0;

    // R8
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit_o && miss_o));

    // R6
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> hit_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid_i |-> (!hit_o && !miss_o && !fault_o && (rpn_o == '0)));

    // R8
    miss_zero_rpn_chk: assert property (@(posedge clk) disable iff (rst)
        miss_o |-> (rpn_o == '0) && !fault_o);
endmodule

// File: tb/boot_tlb_tb.sv
`timescale 1ns/1ps
module boot_tlb_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0;
    logic [19:0] lk_epn = 0;
    logic [7:0]  lk_pid = 0;
    logic        lk_is = 0, lk_ds = 0;
    logic [1:0]  lk_acc = 0;
    logic        hit, miss, fault;
    logic [19:0] rpn;
    logic        wr_en = 0;
    logic [2:0]  wr_idx = 0;
    logic        wr_valid = 0;
    logic [19:0] wr_epn = 0, wr_rpn = 0;
    logic [7:0]  wr_tid = 0;
    logic        wr_ts = 0, wr_px = 0, wr_pr = 0, wr_pw = 0;
    logic        sync = 0;

    always #2.5 clk = ~clk;

    boot_tlb u_dut (
        .clk(clk), .rst(rst),
        .lk_valid_i(lk_valid), .lk_epn_i(lk_epn), .lk_pid_i(lk_pid),
        .lk_is_i(lk_is), .lk_ds_i(lk_ds), .lk_acc_i(lk_acc),
        .hit_o(hit), .miss_o(miss), .fault_o(fault), .rpn_o(rpn),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid),
        .wr_epn_i(wr_epn), .wr_rpn_i(wr_rpn), .wr_tid_i(wr_tid),
        .wr_ts_i(wr_ts), .wr_px_i(wr_px), .wr_pr_i(wr_pr), .wr_pw_i(wr_pw),
        .sync_i(sync)
    );

    // behavioural model state
    bit     m_v[8];
    int     m_epn[8], m_rpn[8], m_tid[8];
    bit     m_ts[8], m_px[8], m_pr[8], m_pw[8];
    bit     m_boot;
    int     n_vec = 0, n_bad = 0;
    bit     done = 0;

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_v[i] = 0;
        m_boot = 1;
    endtask

    task automatic do_reset();
        rst = 1; lk_valid = 0; wr_en = 0; sync = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic look(input bit v, input int epn, input int pid,
                        input bit is_b, input bit ds_b, input int acc);
        lk_valid = v; lk_epn = epn[19:0]; lk_pid = pid[7:0];
        lk_is = is_b; lk_ds = ds_b; lk_acc = acc[1:0];
    endtask

    task automatic wr(input int idx, input bit v, input int epn, input int rp,
                      input int tid, input bit ts, input bit px, input bit pr, input bit pw);
        wr_en = 1; wr_idx = idx[2:0]; wr_valid = v; wr_epn = epn[19:0];
        wr_rpn = rp[19:0]; wr_tid = tid[7:0]; wr_ts = ts;
        wr_px = px; wr_pr = pr; wr_pw = pw;
    endtask

    // compare outputs, then clock, then update model
    task automatic step(input string tag);
        bit e_hit, e_fault, perm, sp, from_boot;
        int e_rpn, acc;
        #1;
        acc = int'(lk_acc);
        sp = (acc == 0) ? lk_is : lk_ds;
        e_hit = 0; e_rpn = 0; perm = 0; from_boot = 0;
        if (lk_valid) begin
            for (int i = 0; i < 8; i++) begin
                if (!e_hit && m_v[i] && m_epn[i] == int'(lk_epn) && m_ts[i] == sp
                    && (m_tid[i] == 0 || m_tid[i] == int'(lk_pid))) begin
                    e_hit = 1; e_rpn = m_rpn[i];
                    perm = (acc == 0) ? m_px[i] : (acc == 2) ? m_pw[i] : m_pr[i];
                end
            end
            if (!e_hit && m_boot && lk_epn == 20'hFFFFF && sp == 0) begin
                e_hit = 1; e_rpn = 'hFFFFF; from_boot = 1;
                perm = (acc != 2);
            end
        end
        e_fault = e_hit && !perm;
        n_vec++;
        if (hit !== e_hit || miss !== (lk_valid && !e_hit) || fault !== e_fault
            || rpn !== e_rpn[19:0]) begin
            n_bad++;
            $display("FAIL %s: got hit=%0b miss=%0b fault=%0b rpn=%h, exp hit=%0b miss=%0b fault=%0b rpn=%h",
                     tag, hit, miss, fault, rpn, e_hit, lk_valid && !e_hit, e_fault, e_rpn[19:0]);
        end
        @(posedge clk);
        if (sync) m_boot = 0;
        if (from_boot && acc == 2) m_boot = 0;
        if (wr_en) begin
            m_v[wr_idx] = wr_valid; m_epn[wr_idx] = int'(wr_epn);
            m_rpn[wr_idx] = int'(wr_rpn); m_tid[wr_idx] = int'(wr_tid);
            m_ts[wr_idx] = wr_ts; m_px[wr_idx] = wr_px;
            m_pr[wr_idx] = wr_pr; m_pw[wr_idx] = wr_pw;
        end
        @(negedge clk);
        wr_en = 0; sync = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 boot page fetch and read, R8 miss elsewhere, R10 idle
        look(1, 'hFFFFF, 5, 0, 0, 0); step("R1");
        look(1, 'hFFFFF, 9, 0, 0, 1); step("R1");
        look(1, 'h01000, 0, 0, 0, 1); step("R8");
        look(0, 'hFFFFF, 0, 0, 0, 2); step("R10");
        look(1, 'hFFFFF, 0, 0, 0, 0); step("R10");
        // R5 boot entry is TS 0
        look(1, 'hFFFFF, 0, 1, 0, 0); step("R5");
        look(1, 'hFFFFF, 0, 1, 1, 1); step("R5");
        // R9 write then lookup
        wr(0, 1, 'h10, 'hABCD, 0, 0, 1, 1, 0);
        look(1, 'h10, 3, 0, 0, 1); step("R9");
        look(1, 'h10, 3, 0, 0, 1); step("R9");
        // R4 TID compare, R5 space bits
        wr(1, 1, 'h20, 'h2222, 7, 1, 1, 1, 1);
        look(1, 'h20, 7, 0, 1, 1); step("R9");
        look(1, 'h20, 7, 0, 1, 1); step("R4");
        look(1, 'h20, 6, 0, 1, 1); step("R4");
        look(1, 'h10, 200, 0, 0, 1); step("R4");
        look(1, 'h20, 7, 0, 0, 1); step("R5");
        look(1, 'h20, 7, 1, 0, 0); step("R5");
        look(1, 'h20, 7, 0, 1, 0); step("R5");
        // R7 lowest index wins
        wr(3, 1, 'h30, 'h3333, 0, 0, 1, 1, 1); look(0, 0, 0, 0, 0, 0); step("R9");
        wr(2, 1, 'h30, 'h2020, 0, 0, 0, 1, 0);
        look(1, 'h30, 0, 0, 0, 2); step("R7");
        look(1, 'h30, 0, 0, 0, 2); step("R7");
        // R6 permissions
        wr(4, 1, 'h40, 'h4444, 0, 0, 0, 1, 1); look(1, 'h10, 0, 0, 0, 2); step("R6");
        look(1, 'h40, 0, 0, 0, 0); step("R6");
        look(1, 'h40, 0, 0, 0, 1); step("R6");
        look(1, 'h40, 0, 0, 0, 2); step("R6");
        look(1, 'h40, 0, 0, 0, 3); step("R6");
        // R7 indexed entry shadows boot page: store OK, boot survives
        wr(5, 1, 'hFFFFF, 'h55555, 0, 0, 1, 1, 1); look(0, 0, 0, 0, 0, 0); step("R9");
        look(1, 'hFFFFF, 0, 0, 0, 2); step("R7");
        wr(5, 0, 'hFFFFF, 'h55555, 0, 0, 1, 1, 1); look(1, 'hFFFFF, 0, 0, 0, 0); step("R7");
        // R2 faulting store discards boot entry
        look(1, 'hFFFFF, 0, 0, 0, 2); step("R2");
        look(1, 'hFFFFF, 0, 0, 0, 0); step("R2");
        look(1, 'hFFFFF, 0, 0, 0, 1); step("R2");
        // R3 sync discards boot entry
        do_reset();
        look(1, 'hFFFFF, 0, 0, 0, 0); step("R1");
        look(1, 'h10, 0, 0, 0, 1); step("R1");
        sync = 1; look(1, 'hFFFFF, 0, 0, 0, 0); step("R3");
        look(1, 'hFFFFF, 0, 0, 0, 0); step("R3");
        look(1, 'hFFFFF, 0, 0, 0, 1); step("R3");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            int pick, pages[5];
            pages = '{'h10, 'h20, 'h30, 'h40, 'hFFFFF};
            if (n % 700 == 0) do_reset();
            if ($urandom_range(0, 3) == 0)
                wr($urandom_range(0, 7), $urandom_range(0, 3) != 0,
                   pages[$urandom_range(0, 4)], $urandom_range(0, 'hFFFFF),
                   ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, 3),
                   $urandom_range(0, 1), $urandom_range(0, 1),
                   $urandom_range(0, 1), $urandom_range(0, 1));
            sync = ($urandom_range(0, 199) == 0);
            pick = $urandom_range(0, 5);
            look($urandom_range(0, 7) != 0,
                 (pick == 5) ? $urandom_range(0, 'hFFFFF) : pages[pick],
                 $urandom_range(0, 3), $urandom_range(0, 1),
                 $urandom_range(0, 1), $urandom_range(0, 3));
            step("R7");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule